// File: doc/BRIEF.md
# Strided Vector Load/Store Address Generator

This block expands one load or store whose data register is set up as a vector into a series of element requests. Each element request carries a memory byte address and the register number that the element's data belongs to. Two offset entries can be written by a set-offset command. Each entry holds a base register number, the register bank it applies to, a stride-mode bit and an offset amount. When a request arrives, its base register and bank are compared with the stored entries. A matching entry adds its amount to the base address. The entry's mode bit then selects whether successive elements are spaced by the immediate of the instruction (stride mode) or are packed end to end (unit mode).

Element requests leave one per cycle over a valid/ready handshake. Destination registers count upward from the data register. A single-cycle done pulse marks the end of the sequence. A new request is taken only while the block is idle.

Top module: `vec_stride_agu`

## Requirements
- R1: After reset no element is valid, `ls_ready` is 1, `ls_done` is 0, and both offset entries are empty, so every request runs in unit mode starting at `ls_base_val`.
- R2: A set-offset command (`set_valid`=1) writes entry `set_slot` with the register number, bank, mode and amount. A later request whose base register and bank both equal that entry starts at `ls_base_val + set_amount`.
- R3: An entry matches only when both the register number and the bank bit are equal. A request that matches no entry starts at `ls_base_val` and runs in unit mode.
- R4: When both entries match, entry 0 supplies the amount and the mode.
- R5: When the matched entry has `set_stride`=1, element i sits at start + i*imm, with the 12-bit `ls_imm` sign-extended. Negative and zero strides are allowed.
- R6: In unit mode the address step is the element size in bytes, taken from `ls_ewidth`: 0 gives 4 (plain word), 1 gives 1, 2 gives 2 and 3 gives 8.
- R7: The number of elements equals `ls_vlen`, and 0 is treated as 1. Element i targets register (`ls_dst_reg` + i) mod 32. `el_last` is 1 only on the final element.
- R8: A valid element holds its address, register and last flag unchanged while `el_ready` is 0. The block moves to the next element only after a handshake.
- R9: `ls_done` is 1 for exactly the one cycle after the handshake of the last element, and `ls_ready` is 1 in that cycle. A request is accepted only while no element is pending.
- R10: If a set-offset command and an accepted request fall in the same cycle, the lookup uses the entry contents from before the write. The next request sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Set-offset command strobe |
| set_slot | input | 1 | Entry index to write |
| set_reg | input | 5 | Base register number the entry applies to |
| set_fbank | input | 1 | Bank: 1 float, 0 integer |
| set_stride | input | 1 | 1 = immediate is element stride, 0 = unit |
| set_amount | input | 32 | Offset amount (source register contents) |
| ls_valid | input | 1 | Load/store request valid |
| ls_ready | output | 1 | Block idle, request can be taken |
| ls_base_reg | input | 5 | Base register number of the request |
| ls_fbank | input | 1 | Bank of the base register |
| ls_base_val | input | 32 | Contents of the base register |
| ls_imm | input | 12 | Instruction immediate |
| ls_dst_reg | input | 5 | First data register |
| ls_vlen | input | 4 | Vector length of the data register |
| ls_ewidth | input | 2 | Packed element width code |
| el_valid | output | 1 | Element request valid |
| el_ready | input | 1 | Element request taken |
| el_addr | output | 32 | Element byte address |
| el_reg | output | 5 | Element register number |
| el_last | output | 1 | Final element of the sequence |
| ls_done | output | 1 | One-cycle completion pulse |

## Verification
Two events can coincide. A set-offset write can land in the same cycle that a request is accepted, and a done pulse can appear in the same cycle that the next request is presented. To provoke the first case, the bench drives `set_valid` and `ls_valid` on the same edge with a changed amount. It then checks that the first element still carries the old amount, and that a following request carries the new one. For the second case, the bench checks that `ls_ready` is high while `ls_done` pulses, and that a request issued straight after the pulse starts a clean sequence.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        EW_WORD = 2'd0,
        EW_B8   = 2'd1,
        EW_B16  = 2'd2,
        EW_B64  = 2'd3
    } ewidth_e;

    function automatic logic [3:0] elem_bytes(input ewidth_e ew);
        case (ew)
            EW_B8:   elem_bytes = 4'd1;
            EW_B16:  elem_bytes = 4'd2;
            EW_B64:  elem_bytes = 4'd8;
            default: elem_bytes = 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/agu_offset_table.sv
module agu_offset_table #(
    parameter int XLEN   = 32,
    parameter int REG_W  = 5,
    parameter int N_ENT  = 2,
    parameter int SLOT_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic              wr_fbank,
    input  logic              wr_stride,
    input  logic [XLEN-1:0]   wr_amount,
    input  logic [REG_W-1:0]  lk_reg,
    input  logic              lk_fbank,
    output logic              lk_hit,
    output logic              lk_stride,
    output logic [XLEN-1:0]   lk_amount
);

    typedef struct packed {
        logic             used;
        logic [REG_W-1:0] rnum;
        logic             fbank;
        logic             stride;
        logic [XLEN-1:0]  amount;
    } ent_t;

    ent_t [N_ENT-1:0] tab_d, tab_q;
    logic [N_ENT-1:0] hit_vec;

    always_comb begin
        tab_d = tab_q;
        for (int i = 0; i < N_ENT; i++) begin
            if (wr_en && (wr_slot == SLOT_W'(i))) begin
                tab_d[i].used   = 1'b1;
                tab_d[i].rnum   = wr_reg;
                tab_d[i].fbank  = wr_fbank;
                tab_d[i].stride = wr_stride;
                tab_d[i].amount = wr_amount;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_match
        assign hit_vec[g] = tab_q[g].used && (tab_q[g].rnum == lk_reg) &&
                            (tab_q[g].fbank == lk_fbank);
    end

    // lowest index wins: scan from the top so the lowest match is written last
    always_comb begin
        lk_hit    = 1'b0;
        lk_stride = 1'b0;
        lk_amount = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                lk_hit    = 1'b1;
                lk_stride = tab_q[i].stride;
                lk_amount = tab_q[i].amount;
            end
        end
    end

endmodule

// File: rtl/agu_addr_plan.sv
module agu_addr_plan
    import agu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12
) (
    input  logic [XLEN-1:0]  base_val,
    input  logic [IMM_W-1:0] imm,
    input  ewidth_e          ewidth,
    input  logic             hit,
    input  logic             stride_mode,
    input  logic [XLEN-1:0]  amount,
    output logic [XLEN-1:0]  start_addr,
    output logic [XLEN-1:0]  step
);

    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] unit_step;

    assign imm_sx    = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign unit_step = XLEN'(elem_bytes(ewidth));

    always_comb begin
        start_addr = hit ? (base_val + amount) : base_val;
        step       = (hit && stride_mode) ? imm_sx : unit_step;
    end

endmodule

// File: rtl/agu_seq.sv
module agu_seq #(
    parameter int XLEN  = 32,
    parameter int REG_W = 5,
    parameter int VL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [XLEN-1:0]  start_addr,
    input  logic [XLEN-1:0]  step,
    input  logic [REG_W-1:0] dst_reg,
    input  logic [VL_W-1:0]  vlen,
    input  logic             out_ready,
    output logic             busy,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_addr,
    output logic [REG_W-1:0] out_reg,
    output logic             out_last,
    output logic             done
);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [XLEN-1:0]  addr;
        logic [XLEN-1:0]  step;
        logic [REG_W-1:0] rnum;
        logic [VL_W-1:0]  left;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (out_ready) begin
                if (st_q.left == '0) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.addr = st_q.addr + st_q.step;
                    st_d.rnum = st_q.rnum + REG_W'(1);
                    st_d.left = st_q.left - VL_W'(1);
                end
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.addr = start_addr;
            st_d.step = step;
            st_d.rnum = dst_reg;
            st_d.left = (vlen == '0) ? '0 : (vlen - VL_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign out_valid = st_q.busy;
    assign out_addr  = st_q.addr;
    assign out_reg   = st_q.rnum;
    assign out_last  = st_q.busy && (st_q.left == '0);
    assign done      = st_q.done;

endmodule

// File: rtl/vec_stride_agu.sv
module vec_stride_agu
    import agu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_W  = 5,
    parameter int VL_W   = 4,
    parameter int IMM_W  = 12,
    parameter int N_OFFS = 2,
    localparam int SLOT_W = (N_OFFS > 1) ? $clog2(N_OFFS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_valid,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic [REG_W-1:0]  set_reg,
    input  logic              set_fbank,
    input  logic              set_stride,
    input  logic [XLEN-1:0]   set_amount,
    input  logic              ls_valid,
    output logic              ls_ready,
    input  logic [REG_W-1:0]  ls_base_reg,
    input  logic              ls_fbank,
    input  logic [XLEN-1:0]   ls_base_val,
    input  logic [IMM_W-1:0]  ls_imm,
    input  logic [REG_W-1:0]  ls_dst_reg,
    input  logic [VL_W-1:0]   ls_vlen,
    input  logic [1:0]        ls_ewidth,
    output logic              el_valid,
    input  logic              el_ready,
    output logic [XLEN-1:0]   el_addr,
    output logic [REG_W-1:0]  el_reg,
    output logic              el_last,
    output logic              ls_done
);

    logic            hit, stride_mode;
    logic [XLEN-1:0] amount, start_addr, step;
    logic            busy, accept;

    agu_offset_table #(
        .XLEN(XLEN), .REG_W(REG_W), .N_ENT(N_OFFS), .SLOT_W(SLOT_W)
    ) u_tab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(set_valid), .wr_slot(set_slot), .wr_reg(set_reg),
        .wr_fbank(set_fbank), .wr_stride(set_stride), .wr_amount(set_amount),
        .lk_reg(ls_base_reg), .lk_fbank(ls_fbank),
        .lk_hit(hit), .lk_stride(stride_mode), .lk_amount(amount)
    );

    agu_addr_plan #(.XLEN(XLEN), .IMM_W(IMM_W)) u_plan (
        .base_val(ls_base_val), .imm(ls_imm), .ewidth(ewidth_e'(ls_ewidth)),
        .hit(hit), .stride_mode(stride_mode), .amount(amount),
        .start_addr(start_addr), .step(step)
    );

    assign ls_ready = !busy;
    assign accept   = ls_valid && ls_ready;

    agu_seq #(.XLEN(XLEN), .REG_W(REG_W), .VL_W(VL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept),
        .start_addr(start_addr), .step(step), .dst_reg(ls_dst_reg), .vlen(ls_vlen),
        .out_ready(el_ready), .busy(busy), .out_valid(el_valid),
        .out_addr(el_addr), .out_reg(el_reg), .out_last(el_last), .done(ls_done)
    );

endmodule

// File: rtl/vec_stride_agu_chk.sv
module vec_stride_agu_chk #(
    parameter int XLEN  = 32,
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ls_valid,
    input logic             ls_ready,
    input logic [REG_W-1:0] ls_dst_reg,
    input logic             el_valid,
    input logic             el_ready,
    input logic [XLEN-1:0]  el_addr,
    input logic [REG_W-1:0] el_reg,
    input logic             el_last,
    input logic             ls_done
);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (el_valid && !el_ready) |=> (el_valid && $stable(el_addr) &&
                                     $stable(el_reg) && $stable(el_last)));

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_done |-> $past(el_valid && el_ready && el_last));

    // R9
    idle_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ls_ready && el_valid));

    // R7
    reg_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (el_valid && el_ready && !el_last) |=>
            (el_valid && el_reg == $past(el_reg) + REG_W'(1)));

    // R7
    first_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_valid && ls_ready) |=> (el_valid && el_reg == $past(ls_dst_reg)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_done |=> !ls_done);

endmodule

bind vec_stride_agu vec_stride_agu_chk #(.XLEN(XLEN), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ls_valid(ls_valid), .ls_ready(ls_ready),
    .ls_dst_reg(ls_dst_reg), .el_valid(el_valid), .el_ready(el_ready),
    .el_addr(el_addr), .el_reg(el_reg), .el_last(el_last), .ls_done(ls_done)
);

// File: tb/vec_stride_agu_tb.sv
module vec_stride_agu_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        set_valid, set_slot, set_fbank, set_stride;
    logic [4:0]  set_reg;
    logic [31:0] set_amount;
    logic        ls_valid, ls_ready, ls_fbank;
    logic [4:0]  ls_base_reg, ls_dst_reg;
    logic [31:0] ls_base_val;
    logic [11:0] ls_imm;
    logic [3:0]  ls_vlen;
    logic [1:0]  ls_ewidth;
    logic        el_valid, el_ready, el_last, ls_done;
    logic [31:0] el_addr;
    logic [4:0]  el_reg;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    // bench copy of the offset entries, kept from the requirements
    bit          m_used [2];
    logic [4:0]  m_reg  [2];
    bit          m_fb   [2];
    bit          m_sm   [2];
    logic [31:0] m_amt  [2];

    always #4 clk = ~clk;

    vec_stride_agu u_dut (
        .clk(clk), .rst_n(rst_n),
        .set_valid(set_valid), .set_slot(set_slot), .set_reg(set_reg),
        .set_fbank(set_fbank), .set_stride(set_stride), .set_amount(set_amount),
        .ls_valid(ls_valid), .ls_ready(ls_ready), .ls_base_reg(ls_base_reg),
        .ls_fbank(ls_fbank), .ls_base_val(ls_base_val), .ls_imm(ls_imm),
        .ls_dst_reg(ls_dst_reg), .ls_vlen(ls_vlen), .ls_ewidth(ls_ewidth),
        .el_valid(el_valid), .el_ready(el_ready), .el_addr(el_addr),
        .el_reg(el_reg), .el_last(el_last), .ls_done(ls_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ebytes(input logic [1:0] ew);
        case (ew)
            2'd1: ebytes = 32'd1;
            2'd2: ebytes = 32'd2;
            2'd3: ebytes = 32'd8;
            default: ebytes = 32'd4;
        endcase
    endfunction

    task automatic model_set(input bit slot, input logic [4:0] r, input bit fb,
                             input bit sm, input logic [31:0] amt);
        m_used[slot] = 1; m_reg[slot] = r; m_fb[slot] = fb;
        m_sm[slot] = sm; m_amt[slot] = amt;
    endtask

    task automatic do_set(input bit slot, input logic [4:0] r, input bit fb,
                          input bit sm, input logic [31:0] amt);
        @(negedge clk);
        set_valid = 1; set_slot = slot; set_reg = r; set_fbank = fb;
        set_stride = sm; set_amount = amt;
        @(negedge clk);
        set_valid = 0;
        model_set(slot, r, fb, sm, amt);
    endtask

    // issue one request, optionally with a same-cycle entry write (R10)
    task automatic run_ls(input logic [4:0] breg, input bit fb, input logic [31:0] bval,
                          input logic [11:0] imm, input logic [4:0] dst,
                          input logic [3:0] vl, input logic [1:0] ew, input int seed,
                          input string tag, input bit with_set, input bit s_slot,
                          input logic [31:0] s_amt);
        bit hit = 0; bit sm = 0; logic [31:0] amt = 0;
        logic [31:0] start, step, ea;
        logic [4:0] er;
        int n;
        for (int k = 1; k >= 0; k--)
            if (m_used[k] && m_reg[k] == breg && m_fb[k] == fb) begin
                hit = 1; sm = m_sm[k]; amt = m_amt[k];
            end
        start = hit ? bval + amt : bval;
        step  = (hit && sm) ? {{20{imm[11]}}, imm} : ebytes(ew);
        n     = (vl == 0) ? 1 : int'(vl);

        @(negedge clk);
        chk(ls_done == 0, {tag, " R9 done cleared"}, 32'(ls_done), 0);
        chk(ls_ready == 1, {tag, " R9 ready idle"}, 32'(ls_ready), 1);
        ls_valid = 1; ls_base_reg = breg; ls_fbank = fb; ls_base_val = bval;
        ls_imm = imm; ls_dst_reg = dst; ls_vlen = vl; ls_ewidth = ew;
        if (with_set) begin
            set_valid = 1; set_slot = s_slot; set_reg = breg; set_fbank = fb;
            set_stride = m_sm[s_slot]; set_amount = s_amt;
        end
        @(negedge clk);
        ls_valid = 0;
        if (with_set) begin
            set_valid = 0;
            model_set(s_slot, breg, fb, m_sm[s_slot], s_amt);
        end
        for (int i = 0; i < n; i++) begin
            ea = start + step * 32'(i);
            er = dst + 5'(i);
            for (int s = 0; s < (i + seed) % 3; s++) begin
                chk(el_valid == 1 && el_addr == ea, {tag, " R8 hold addr"}, el_addr, ea);
                chk(el_reg == er, {tag, " R8 hold reg"}, 32'(el_reg), 32'(er));
                @(negedge clk);
            end
            el_ready = 1;
            chk(el_valid == 1, {tag, " R8 valid"}, 32'(el_valid), 1);
            chk(el_addr == ea, {tag, " R2/R5/R6 addr"}, el_addr, ea);
            chk(el_reg == er, {tag, " R7 reg"}, 32'(el_reg), 32'(er));
            chk(el_last == (i == n - 1), {tag, " R7 last"}, 32'(el_last), 32'(i == n - 1));
            @(negedge clk);
            el_ready = 0;
        end
        chk(ls_done == 1, {tag, " R9 done pulse"}, 32'(ls_done), 1);
        chk(ls_ready == 1 && el_valid == 0, {tag, " R9 idle at done"},
            {30'd0, ls_ready, el_valid}, 32'd2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; set_valid = 0; set_slot = 0; set_reg = 0; set_fbank = 0;
        set_stride = 0; set_amount = 0; ls_valid = 0; ls_base_reg = 0; ls_fbank = 0;
        ls_base_val = 0; ls_imm = 0; ls_dst_reg = 0; ls_vlen = 0; ls_ewidth = 0;
        el_ready = 0;
        for (int k = 0; k < 2; k++) begin m_used[k] = 0; m_reg[k] = 0; m_fb[k] = 0;
            m_sm[k] = 0; m_amt[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(el_valid == 0, "R1 no element", 32'(el_valid), 0);
        chk(ls_ready == 1, "R1 ready", 32'(ls_ready), 1);
        chk(ls_done == 0, "R1 no done", 32'(ls_done), 0);

        // R1/R3/R6/R7 empty table: unit mode sweep over widths and lengths
        for (int ew = 0; ew < 4; ew++)
            for (int vl = 0; vl < 6; vl++)
                run_ls(5'd3, 0, 32'h1000 + 32'(ew * 64), 12'h7f0, 5'(vl), 4'(vl),
                       2'(ew), vl + ew, "R1_empty", 0, 0, 0);

        // R2/R4/R5 both entries on reg 3 int; entry 0 stride, entry 1 unit
        do_set(1, 5'd3, 0, 0, 32'h40);
        do_set(0, 5'd3, 0, 1, 32'h100);
        for (int t = 0; t < 3; t++)
            for (int vl = 1; vl < 5; vl++)
                run_ls(5'd3, 0, 32'h2000, (t == 0) ? 12'd8 : (t == 1) ? 12'hff8 : 12'd0,
                       5'd8, 4'(vl), 2'd1, t + vl, "R4_R5_stride", 0, 0, 0);

        // R3 bank mismatch: move entry 0 to float bank; int request hits entry 1
        do_set(0, 5'd3, 1, 1, 32'h100);
        for (int ew = 0; ew < 4; ew++)
            run_ls(5'd3, 0, 32'h3000, 12'd20, 5'd1, 4'd3, 2'(ew), ew, "R3_R6_unit_hit", 0, 0, 0);
        run_ls(5'd3, 1, 32'h3000, 12'd20, 5'd1, 4'd3, 2'd0, 1, "R3_R5_float_hit", 0, 0, 0);
        run_ls(5'd4, 0, 32'h3000, 12'd20, 5'd1, 4'd3, 2'd2, 2, "R3_nomatch", 0, 0, 0);

        // R7 register wrap and longest vector
        run_ls(5'd4, 0, 32'h4000, 12'd0, 5'd30, 4'd4, 2'd0, 0, "R7_wrap", 0, 0, 0);
        run_ls(5'd4, 0, 32'h4000, 12'd0, 5'd20, 4'd15, 2'd3, 1, "R7_long", 0, 0, 0);

        // R10 same-cycle write: old amount used, new amount on next request
        run_ls(5'd3, 1, 32'h5000, 12'd4, 5'd2, 4'd2, 2'd0, 0, "R10_same_cycle",
               1, 0, 32'h800);
        run_ls(5'd3, 1, 32'h5000, 12'd4, 5'd2, 4'd2, 2'd0, 0, "R10_after", 0, 0, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule